// File: doc/BRIEF.md
# Serial Audio Input Rate Classifier

This block watches a biphase-mark coded digital audio line and decides which of seven standard sample rates it carries, or that no signal is present. The line is brought into the fast reference clock domain through a two-stage synchroniser. Every clock edge of the line restarts a cycle counter. Over a programmable window of reference cycles, the block keeps the largest edge-to-edge interval it has seen. At the end of each window it compares that maximum against a ladder of six programmable thresholds and publishes a 3-bit rate code.

Rate codes 0 to 6 stand for 32000, 44100, 48000, 88200, 96000, 176400 and 192000 Hz, in that order. Code 7 means no signal. Longer intervals belong to slower rates, so the thresholds decrease as the code rises. Software programs the window to one millisecond of reference cycles and sets threshold i between the interval lengths of rates i and i+1. A sticky flag records every change of the code, and a mask routes it to an interrupt line.

Top module: `spdif_rate_detect`

## Requirements
- R1: After reset the status word reads code 7, maximum width 0 and flags 0, and `irq_o` is low.
- R2: At each window end the maximum-width field shows the longest interval, in reference cycles, between two consecutive synchronised input edges seen in that window. The interval before the first edge after reset is not measured.
- R3: The code is the lowest i in 0..5 whose threshold the maximum width strictly exceeds. When no threshold is exceeded the code is 6. A width equal to a threshold does not exceed it.
- R4: A window with no measured edge gives code 7 and maximum width 0.
- R5: The interval counter saturates at 2**WIDTH_W-1, and an interval longer than that is reported as that value.
- R6: Flag bit 2 is set at a window end whose code differs from the previous code. A window that repeats the code leaves the flag unchanged.
- R7: Writing address 4 clears each flag whose data bit is 1 (bits 7:0). Flags whose data bit is 0 are left unchanged.
- R8: `irq_o` is high exactly when some flag is set whose bit is also set in the mask.
- R9: Write map. Address 0 bits 19:0 hold the window length. Address 1 bits 7:0 hold the mask. Address 2 holds thresholds 0, 1 and 2 in bits 31:22, 21:12 and 11:2. Address 3 holds thresholds 3, 4 and 5 in the same three slots. The lowest code always takes the most significant slot.
- R10: The status word carries the code in bits 30:28, the maximum width in bits 17:8 and the flags in bits 7:0. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sdin | input | 1 | Asynchronous biphase-mark input line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| status_o | output | 32 | Code, maximum width and flags |
| irq_o | output | 1 | Masked flag interrupt |

## Verification
The bench keeps the default widths: 10-bit intervals, a 20-bit window and 32-bit words. It writes a 300-cycle window and thresholds 60 down to 10. With these values every rate code, the equal-to-threshold boundary and the silent case each take a few hundred cycles to reach. A temporary 3000-cycle window lets an 1100-cycle input interval drive the counter to its saturation value of 1023.

// File: rtl/spdif_rd_pkg.sv
package spdif_rd_pkg;
   localparam int NUM_THR = 6;
   localparam int MODE_W  = 3;
   typedef logic [MODE_W-1:0] mode_t;
   localparam mode_t MODE_FASTEST = 3'd6;
   localparam mode_t MODE_NOSIG   = 3'd7;
endpackage

// File: rtl/spdif_edge_sync.sv
module spdif_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic edge_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("spdif_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], din};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/spdif_interval_meter.sv
module spdif_interval_meter #(
   parameter int WIDTH_W = 10,
   parameter int BASE_W  = 20
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               edge_i,
   input  logic [BASE_W-1:0]  win_len_i,
   output logic               done_o,
   output logic [WIDTH_W-1:0] max_o
);
   localparam logic [WIDTH_W-1:0] CNT_MAX = {WIDTH_W{1'b1}};

   logic [WIDTH_W-1:0] cnt_q, run_q, sample, upd;
   logic [BASE_W-1:0]  win_q;
   logic               seen_q, win_end;

   assign sample  = (edge_i && seen_q) ? cnt_q : '0;
   assign upd     = (sample > run_q) ? sample : run_q;
   assign win_end = (win_q >= win_len_i - 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (edge_i) begin
         cnt_q  <= {{(WIDTH_W-1){1'b0}}, 1'b1};
         seen_q <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q  <= '0;
         run_q  <= '0;
         done_o <= 1'b0;
         max_o  <= '0;
      end else if (win_end) begin
         win_q  <= '0;
         run_q  <= '0;
         done_o <= 1'b1;
         max_o  <= upd;
      end else begin
         win_q  <= win_q + 1'b1;
         run_q  <= upd;
         done_o <= 1'b0;
      end
   end

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_MAX && !edge_i) |=> cnt_q == CNT_MAX); // R5
   AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (rst)
      edge_i |=> cnt_q == 1); // R2
endmodule

// File: rtl/spdif_mode_classifier.sv
module spdif_mode_classifier
   import spdif_rd_pkg::*;
#(
   parameter int WIDTH_W = 10
) (
   input  logic [WIDTH_W-1:0] maxw_i,
   input  logic [WIDTH_W-1:0] thr_i [NUM_THR],
   output mode_t              mode_o
);
   logic [NUM_THR-1:0] over;

   generate
      for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
         assign over[g] = maxw_i > thr_i[g];
      end
   endgenerate

   always_comb begin
      mode_o = MODE_FASTEST;
      for (int i = NUM_THR - 1; i >= 0; i--) begin
         if (over[i]) mode_o = mode_t'(i);
      end
      if (maxw_i == '0) mode_o = MODE_NOSIG;
   end
endmodule

// File: rtl/spdif_rate_detect.sv
module spdif_rate_detect
   import spdif_rd_pkg::*;
#(
   parameter int WIDTH_W  = 10,
   parameter int BASE_W   = 20,
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 32,
   parameter int FLAG_W   = 8,
   parameter int CHG_BIT  = 2,
   parameter int SYNC_N   = 2,
   parameter int WIN_DEF  = 333333
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sdin,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] status_o,
   output logic              irq_o
);
   localparam int THR_PER = 3;
   localparam int SLOT_W  = DATA_W / THR_PER;
   localparam logic [ADDR_W-1:0] A_WIN  = 0;
   localparam logic [ADDR_W-1:0] A_MASK = 1;
   localparam logic [ADDR_W-1:0] A_THRA = 2;
   localparam logic [ADDR_W-1:0] A_THRB = 3;
   localparam logic [ADDR_W-1:0] A_CLR  = 4;

   generate
      if (SLOT_W < WIDTH_W || DATA_W < 31 || BASE_W > DATA_W || FLAG_W > 8 || CHG_BIT >= FLAG_W)
         begin : g_bad
         $error("spdif_rate_detect: inconsistent parameters");
      end
   endgenerate

   logic [BASE_W-1:0]  win_q;
   logic [FLAG_W-1:0]  mask_q, flags_q, clr;
   logic [WIDTH_W-1:0] thr_q [NUM_THR];
   logic [WIDTH_W-1:0] meas_max, maxw_q;
   logic               edge_s, done;
   mode_t              mode_q, mode_new;

   spdif_edge_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst(rst), .din(sdin), .edge_o(edge_s));

   spdif_interval_meter #(.WIDTH_W(WIDTH_W), .BASE_W(BASE_W)) u_meter (
      .clk(clk), .rst(rst), .edge_i(edge_s), .win_len_i(win_q),
      .done_o(done), .max_o(meas_max));

   spdif_mode_classifier #(.WIDTH_W(WIDTH_W)) u_cls (
      .maxw_i(meas_max), .thr_i(thr_q), .mode_o(mode_new));

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q  <= BASE_W'(WIN_DEF);
         mask_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_WIN)  win_q  <= wr_data[BASE_W-1:0];
         if (wr_addr == A_MASK) mask_q <= wr_data[FLAG_W-1:0];
      end
   end

   generate
      for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
         localparam logic [ADDR_W-1:0] MY_ADDR = A_THRA + ADDR_W'(t / THR_PER);
         localparam int TOP = DATA_W - 1 - (t % THR_PER) * SLOT_W;
         always_ff @(posedge clk) begin
            if (rst) thr_q[t] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
               thr_q[t] <= wr_data[TOP -: WIDTH_W];
         end
      end
   endgenerate

   assign clr = (wr_en && wr_addr == A_CLR) ? wr_data[FLAG_W-1:0] : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q  <= MODE_NOSIG;
         maxw_q  <= '0;
         flags_q <= '0;
      end else begin
         flags_q <= flags_q & ~clr;
         if (done) begin
            mode_q <= mode_new;
            maxw_q <= meas_max;
            if (mode_new != mode_q) flags_q[CHG_BIT] <= 1'b1;
         end
      end
   end

   always_comb begin
      status_o        = '0;
      status_o[30:28] = mode_q;
      status_o[8 +: WIDTH_W] = maxw_q;
      status_o[FLAG_W-1:0]   = flags_q;
   end

   assign irq_o = |(flags_q & mask_q);

   AST_NOSIG_ZERO: assert property (@(posedge clk) disable iff (rst)
      (maxw_q == '0) |-> (mode_q == MODE_NOSIG)); // R4
   AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
      (done && mode_new != mode_q) |=> flags_q[CHG_BIT]); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flags_q[CHG_BIT] && !clr[CHG_BIT]) |=> flags_q[CHG_BIT]); // R7
endmodule

// File: tb/spdif_rate_detect_bench.sv
module spdif_rate_detect_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WIN = 300;
   localparam int NV  = 8;
   localparam int VP [NV] = '{70, 55, 45, 35, 25, 15, 5, 60};
   localparam int VM [NV] = '{0, 1, 2, 3, 4, 5, 6, 1};

   logic clk = 0, rst = 1, sdin = 0, wr_en = 0, irq_o;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0, status_o;
   int per = 0, tc = 0, n_run = 0, n_fail = 0;
   bit done_flag = 0;

   spdif_rate_detect u_spdif_rate_detect (
      .clk(clk), .rst(rst), .sdin(sdin), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .status_o(status_o), .irq_o(irq_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (per != 0) begin
         if (tc >= per - 1) begin tc <= 0; sdin <= ~sdin; end
         else tc <= tc + 1;
      end else tc <= 0;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      wait_cyc(3); rst = 0; wait_cyc(1);
      chk("R1 status", status_o, 32'h7000_0000);
      chk("R1 irq", {31'b0, irq_o}, 0);
      // R9: window, thresholds 60..10 with lowest code in the top slot
      wr(3'd0, WIN);
      wr(3'd2, (32'd60 << 22) | (32'd50 << 12) | (32'd40 << 2));
      wr(3'd3, (32'd30 << 22) | (32'd20 << 12) | (32'd10 << 2));
      for (int v = 0; v < NV; v++) begin
         per = VP[v];
         wait_cyc(3 * WIN);
         chk("R2 maxw", {22'b0, status_o[17:8]}, VP[v]);
         chk("R3 mode", {29'b0, status_o[30:28]}, VM[v]);
         chk("R6 flag set", {31'b0, status_o[2]}, 1);
         wr(3'd4, 32'h04);
         chk("R7 cleared", {24'b0, status_o[7:0]}, 0);
         wait_cyc(WIN + 5);
         chk("R6 no change", {31'b0, status_o[2]}, 0);
      end
      // R5 saturation
      wr(3'd0, 3000); per = 1100;
      wait_cyc(9000);
      chk("R5 sat", {22'b0, status_o[17:8]}, 1023);
      chk("R3 sat mode", {29'b0, status_o[30:28]}, 0);
      // R4 silence
      wr(3'd0, WIN); per = 0;
      wait_cyc(3 * WIN);
      chk("R4 nosig", status_o, 32'h7000_0004);
      // R8 mask; R7 clearing with zero bits keeps flag
      wr(3'd4, 32'h00);
      chk("R7 keep", {31'b0, status_o[2]}, 1);
      chk("R8 masked", {31'b0, irq_o}, 0);
      wr(3'd1, 32'h04);
      chk("R8 unmasked", {31'b0, irq_o}, 1);
      wr(3'd4, 32'hFF);
      chk("R8 cleared", {31'b0, irq_o}, 0);
      per = 25;
      wait_cyc(3 * WIN);
      chk("R10 status", status_o, 32'h4000_1904);
      chk("R8 irq", {31'b0, irq_o}, 1);
      done_flag = 1;
   end

   initial begin
      wait_cyc(150000);
      if (!done_flag) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      wait (done_flag == 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule